// File: doc/BRIEF.md
# Variable-Length Bit Accumulator

This block collects a serial bit stream that arrives in fixed-width beats, where each beat carries a run-time count of valid bits (zero up to the full beat width), and packs those bits without gaps into a wide working vector. The first bit lands at index 0, and every later bit lands at the next free index. A position register holds that next free index. Each beat is placed by a barrel shift of the masked beat by the position, and the shifted beat is ORed into the vector. No variable-range slice is used.

The block stops taking beats when one of two things happens: the vector is full, or the sender flags the end of a message. It then offers the vector, its fill count and an end-of-message flag to a downstream stage over a valid/ready handshake. When that stage accepts, the vector is cleared and intake resumes. A beat can hold more bits than the vector has room for. The extra bits are kept in a beat-wide overflow register and become the first bits of the next vector. A message of any length can therefore span several vectors.

Top module: `bit_gather`

## Requirements
- R1: After synchronous active-low reset, `in_ready` is 1, `out_valid` is 0, `out_fill` is 0 and `out_vec` is all zero.
- R2: In an accepted beat, bits `in_data[k]` for k < length are written to vector index fill+k. Bits of `in_data` at or above the length are ignored.
- R3: An accepted beat advances `out_fill` by its length. A length above the beat width counts as the beat width.
- R4: When an accepted beat brings the fill to the vector width, the next cycle shows `out_valid` = 1, `out_fill` = vector width and `in_ready` = 0.
- R5: An accepted beat with `in_last` = 1 that does not overflow the vector causes the vector to be presented with `out_last` = 1 and the fill reached so far.
- R6: While `out_valid` is 1, `in_ready` is 0. The vector, fill and last flag hold steady until `out_ready` is seen.
- R7: Bits of a beat that do not fit are presented, after the full vector is accepted, as indices 0 upward of the next vector. The fill of that vector starts at the number of excess bits.
- R8: If an overflowing beat also carries `in_last`, the full vector is presented with `out_last` = 0. Once it is accepted, the vector holding the excess bits is presented at once with `out_last` = 1 and no further input.
- R9: A beat with length 0 and `in_last` = 1 on an empty vector produces a block with `out_fill` = 0 and `out_last` = 1.
- R10: Every `out_vec` bit at an index at or above `out_fill` is 0.
- R11: Once a block with no pending end-of-message overflow is accepted, the next cycle shows `in_ready` = 1 and the new fill equal to the overflow count (0 if none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | BEAT_W | Beat bits, valid from bit 0 upward |
| in_len | input | LEN_W | Number of valid bits in the beat |
| in_last | input | 1 | Beat ends the current message |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| out_vec | output | VEC_W | Packed working vector |
| out_fill | output | POS_W | Number of valid bits in `out_vec` |
| out_last | output | 1 | Block ends a message |
| out_valid | output | 1 | Block offered downstream |
| out_ready | input | 1 | Downstream takes the block |

## Verification
Two functions can fall in the same cycle: closing a message and overflowing the vector. This happens when one beat both crosses the vector end and carries the end-of-message flag. The bench builds this case directly, with a beat of length 20 on a fill of 1016. Random streams with lengths that often straddle the boundary, together with a frequent last flag, produce it again many times. A behavioural bit-queue model judges every cycle. The model expects the full block with the flag clear, then the 12-bit remainder block with the flag set, and no beat taken between the two.

// File: rtl/bit_gather.sv
module bit_gather #(
  parameter int VEC_W  = 1024,
  parameter int BEAT_W = 64,
  localparam int LEN_W = $clog2(BEAT_W + 1),
  localparam int POS_W = $clog2(VEC_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BEAT_W-1:0] in_data,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [VEC_W-1:0]  out_vec,
  output logic [POS_W-1:0]  out_fill,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int WIDE_W = VEC_W + BEAT_W;
  localparam int SUM_W  = POS_W + 1;

  logic [VEC_W-1:0]  vec_q;
  logic [POS_W-1:0]  pos_q;
  logic              hold_q, last_q;
  logic [BEAT_W-1:0] cry_q;
  logic [LEN_W-1:0]  cry_len_q;
  logic              cry_last_q;

  logic [LEN_W-1:0]  len_eff;
  logic [BEAT_W:0]   keep_mask;
  logic [BEAT_W-1:0] beat_keep;
  logic [WIDE_W-1:0] wide;
  logic [SUM_W-1:0]  sum;
  logic              overrun, spill;
  logic [LEN_W-1:0]  over_len;
  logic              take, release_blk;

  assign len_eff     = (in_len > LEN_W'(BEAT_W)) ? LEN_W'(BEAT_W) : in_len;
  assign keep_mask   = ({{BEAT_W{1'b0}}, 1'b1} << len_eff) - 1'b1;
  assign beat_keep   = in_data & keep_mask[BEAT_W-1:0];
  assign wide        = {{VEC_W{1'b0}}, beat_keep} << pos_q;
  assign sum         = {1'b0, pos_q} + SUM_W'(len_eff);
  assign overrun     = sum >= SUM_W'(VEC_W);
  assign over_len    = LEN_W'(sum - SUM_W'(VEC_W));
  assign spill       = overrun && (over_len != '0);
  assign take        = in_valid && !hold_q;
  assign release_blk = hold_q && out_ready;

  assign in_ready  = !hold_q;
  assign out_valid = hold_q;
  assign out_vec   = vec_q;
  assign out_fill  = pos_q;
  assign out_last  = last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q      <= '0;
      pos_q      <= '0;
      hold_q     <= 1'b0;
      last_q     <= 1'b0;
      cry_q      <= '0;
      cry_len_q  <= '0;
      cry_last_q <= 1'b0;
    end else if (release_blk) begin
      vec_q      <= {{(VEC_W-BEAT_W){1'b0}}, cry_q};
      pos_q      <= POS_W'(cry_len_q);
      hold_q     <= cry_last_q;
      last_q     <= cry_last_q;
      cry_q      <= '0;
      cry_len_q  <= '0;
      cry_last_q <= 1'b0;
    end else if (take) begin
      vec_q      <= vec_q | wide[VEC_W-1:0];
      pos_q      <= overrun ? POS_W'(VEC_W) : sum[POS_W-1:0];
      hold_q     <= overrun || in_last;
      last_q     <= in_last && !spill;
      cry_q      <= wide[WIDE_W-1:VEC_W];
      cry_len_q  <= overrun ? over_len : '0;
      cry_last_q <= in_last && spill;
    end
  end

  p_hold_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && !in_ready && $stable(out_vec)
                                && $stable(out_fill) && $stable(out_last));

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_fill <= POS_W'(VEC_W));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_last && !overrun
    |=> in_ready && out_fill == $past(out_fill) + POS_W'($past(len_eff)));

  p_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && overrun |=> out_valid && out_fill == POS_W'(VEC_W));

  p_zero_above_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vec >> out_fill) == '0);

  p_empty_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last && in_len == '0 && out_fill == '0
    |=> out_valid && out_last && out_fill == '0);

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> out_fill < POS_W'(BEAT_W));
endmodule

// File: tb/bit_gather_tb_top.sv
module bit_gather_tb_top;
  localparam int VW = 1024;
  localparam int BW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BW-1:0] in_data = '0;
  logic [6:0]    in_len = '0;
  logic          in_last = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic          in_ready, out_last, out_valid;
  logic [VW-1:0] out_vec;
  logic [10:0]   out_fill;

  int total = 0, bad = 0, cycles = 0;

  logic [VW-1:0] mvec;
  int            mfill;
  bit            mhold, mlast, clast;
  bit            cq[$];

  always #4 clk = ~clk;

  bit_gather dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_len(in_len),
    .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
    .out_vec(out_vec), .out_fill(out_fill), .out_last(out_last),
    .out_valid(out_valid), .out_ready(out_ready));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(in_ready === !mhold, "R6 in_ready", 64'(in_ready), 64'(!mhold));
    chk(out_valid === mhold, "R4 out_valid", 64'(out_valid), 64'(mhold));
    chk(out_fill === 11'(mfill), "R3 out_fill", 64'(out_fill), 64'(mfill));
    if (mhold) chk(out_last === mlast, "R5 out_last", 64'(out_last), 64'(mlast));
    for (int w = 0; w < VW / 64; w++)
      chk(out_vec[w*64 +: 64] === mvec[w*64 +: 64], "R2 R10 out_vec",
          out_vec[w*64 +: 64], mvec[w*64 +: 64]);
  endtask

  task automatic model_step();
    if (mhold) begin
      if (out_ready) begin
        mvec = '0; mfill = 0;
        while (cq.size() > 0) begin mvec[mfill] = cq.pop_front(); mfill++; end
        mhold = clast; mlast = clast; clast = 0;
      end
    end else if (in_valid) begin
      int l = (in_len > 64) ? 64 : int'(in_len);
      for (int i = 0; i < l; i++) begin
        if (mfill < VW) begin mvec[mfill] = in_data[i]; mfill++; end
        else cq.push_back(in_data[i]);
      end
      if (mfill == VW || in_last) begin
        mhold = 1;
        mlast = in_last && cq.size() == 0;
        clast = in_last && cq.size() > 0;
      end
    end
  endtask

  task automatic cyc(input bit v, input int len, input logic [63:0] d, input bit last, input bit ordy);
    in_valid = v; in_len = 7'(len); in_data = d; in_last = last; out_ready = ordy;
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 64'(0), 64'(1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin
    mvec = '0; mfill = 0; mhold = 0; mlast = 0; clast = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(in_ready === 1'b1 && out_valid === 1'b0 && out_fill === '0 && out_vec === '0,
        "R1 reset", {in_ready, out_valid, 51'd0, out_fill}, 64'h8000_0000_0000_0000);
    compare();

    cyc(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
    chk(out_valid === 1'b1 && out_last === 1'b1 && out_fill === '0, "R9 empty close",
        {out_valid, out_last, 51'd0, out_fill}, 64'hC000_0000_0000_0000);
    cyc(0, 0, '0, 0, 1);
    chk(in_ready === 1'b1 && out_fill === '0, "R11 release", {in_ready, 52'd0, out_fill}, 64'h8000_0000_0000_0000);

    for (int i = 0; i < 16; i++) cyc(1, 64, {$urandom, $urandom}, 0, 0);
    chk(out_valid === 1'b1 && out_fill === 11'd1024 && in_ready === 1'b0, "R4 full",
        64'(out_fill), 64'd1024);
    cyc(1, 64, '1, 0, 0);
    cyc(0, 0, '0, 0, 1);
    chk(in_ready === 1'b1 && out_vec === '0 && out_fill === '0, "R11 cleared", 64'(out_fill), 64'd0);

    for (int i = 0; i < 17; i++) cyc(1, 60, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    cyc(1, 60, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    chk(out_fill === 11'd1024 && out_last === 1'b0, "R4 straddle full", 64'(out_fill), 64'd1024);
    cyc(0, 0, '0, 0, 1);
    chk(out_fill === 11'd56 && out_vec[63:0] === 64'h00FF_FFFF_FFFF_FFFF && in_ready === 1'b1,
        "R7 carry", out_vec[63:0], 64'h00FF_FFFF_FFFF_FFFF);

    for (int i = 0; i < 16; i++) cyc(1, 60, {$urandom, $urandom}, 0, 0);
    cyc(1, 20, 64'h0000_0000_000F_FFFF, 1, 0);
    chk(out_valid === 1'b1 && out_fill === 11'd1024 && out_last === 1'b0, "R8 first block",
        {out_last, 52'd0, out_fill}, 64'd1024);
    cyc(1, 64, '1, 1, 1);
    chk(out_valid === 1'b1 && out_fill === 11'd12 && out_last === 1'b1 && out_vec[63:0] === 64'hFFF,
        "R8 tail block", out_vec[63:0], 64'hFFF);
    cyc(0, 0, '0, 0, 1);
    chk(in_ready === 1'b1 && out_fill === '0, "R11 after tail", 64'(out_fill), 64'd0);

    for (int i = 0; i < 4000; i++)
      cyc($urandom_range(0, 9) < 8, $urandom_range(0, 70), {$urandom, $urandom},
          $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule